// File: doc/BRIEF.md
# Block-Buffered Encoder Read Sequencer

This block runs the read side of a block-buffered turbo-style encoder. Complete input blocks sit in a circular data memory, and their lengths wait in a separate size FIFO. When the sequencer is ready for new work, it pops one length from that FIFO. That length fixes how many data positions are read. It also fixes where the following block begins in the circular memory, since each block starts where the previous one ended, modulo 16384.

For each block the sequencer first issues K natural-order read addresses, where K is the block length. The matching interleaved address is formed from the block base and an index supplied by an external interleaver. The sequencer then produces four trellis-termination cycles. A one-cycle memory read latency is hidden by issuing each address one cycle ahead of its output beat, so the first data bit lines up with the start strobe.

Blocks stream back to back with no idle cycle between them. Framing is therefore carried by one-cycle start and end strobes and not by the valid signal. A downstream ready input freezes the whole read and output path, including the tail cycles. After each block's final tail beat has been accepted, a release pulse returns that block's base address to the write side.

Top module: `tcc_oseq_top`

## Requirements
- R1: While reset is asserted, out_rdy_o, blk_start_o, blk_end_o, tail_o, enc_run_o, rd_en_o and rel_valid_o are all low.
- R2: fifo_pop_o is asserted only when fifo_empty_i is low and dn_ready_i is high, and only while the sequencer is idle or issuing the last tail position of a block. For a block popped from idle, blk_start_o rises at the second clock edge after the pop edge.
- R3: Every block of length K produces exactly K+4 output beats (out_rdy_o high with dn_ready_i high). tail_o is high on the last four of these beats.
- R4: When the next length is already waiting in the FIFO, the first beat of a block directly follows the last beat of the previous block, with no cycle in between.
- R5: blk_start_o is high only on the first beat of a block, and blk_end_o is high only on its last tail beat.
- R6: For the block being read, rd_en_o is high for exactly K accepted cycles. During these cycles rd_addr_o runs from base to base+K-1, modulo 16384, and cur_idx_o runs from 0 to K-1.
- R7: The first block after reset has base 0. Each later block has base equal to the previous base plus the previous length, modulo 16384.
- R8: While rd_en_o is high, il_addr_o equals the current block base plus il_idx_i, modulo 16384.
- R9: When dn_ready_i is low, the registered outputs keep their values across the next clock edge, rd_addr_o does not change, and fifo_pop_o and rd_en_o are low.
- R10: If the FIFO is empty after the last tail beat of a block, out_rdy_o goes low and stays low until a new length arrives.
- R11: rel_valid_o is a one-cycle pulse that follows each accepted blk_end_o beat by one cycle. It carries that block's base address on rel_base_o.
- R12: enc_run_o is high exactly when out_rdy_o and dn_ready_i are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_empty_i | input | 1 | Size FIFO holds no length |
| fifo_size_i | input | 13 | Length at the FIFO head (first-word fall-through) |
| fifo_pop_o | output | 1 | Removes the head length at this clock edge |
| dn_ready_i | input | 1 | Downstream ready; low freezes the read and output path |
| rd_en_o | output | 1 | Data memory read enable for this cycle |
| rd_addr_o | output | 14 | Natural-order data memory address |
| il_idx_i | input | 13 | Interleaved index from the external interleaver |
| il_addr_o | output | 14 | Interleaved data memory address |
| cur_idx_o | output | 13 | Position being read within the block |
| cur_size_o | output | 13 | Length of the block being read |
| out_rdy_o | output | 1 | Output beat valid (data or tail) |
| blk_start_o | output | 1 | First data beat of a block |
| blk_end_o | output | 1 | Last tail beat of a block |
| tail_o | output | 1 | Beat belongs to the termination phase |
| enc_run_o | output | 1 | Encoder stall enable: constituent encoders advance |
| rel_valid_o | output | 1 | Block storage release pulse |
| rel_base_o | output | 14 | Base address of the released block |

## Verification
Two functions can fall in the same cycle: issuing a block's final tail position, and popping the next length and loading its base. If these two collide badly, one beat is lost, a gap cycle appears, or the base is not updated. Back-to-back runs are provoked by queueing several lengths, including length 1, before the FIFO drains. The recorded start and end cycles must then be adjacent. Random downstream stalls are also laid over block boundaries and tail phases. Every beat's position, read address and release base is judged against a bench list of bases built from the popped lengths.

// File: rtl/tcc_oseq_pkg.sv
package tcc_oseq_pkg;

  // Read-side phase of the issue stage
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DATA = 2'd1,
    PH_TAIL = 2'd2
  } oseq_phase_e;

  // One output beat, carried from the issue stage to the output stage
  typedef struct packed {
    logic valid;
    logic first;
    logic last;
    logic tail;
  } oseq_beat_t;

endpackage

// File: rtl/tcc_oseq_ctrl.sv
module tcc_oseq_ctrl
  import tcc_oseq_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int SIZE_W   = 13,
  parameter int TAIL_LEN = 4,
  localparam int POS_W   = SIZE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              fifo_empty,
  input  logic [SIZE_W-1:0] fifo_size,
  output logic              fifo_pop,
  output logic              rd_en,
  output logic [POS_W-1:0]  cur_pos,
  output logic [SIZE_W-1:0] cur_size,
  output logic [ADDR_W-1:0] cur_base,
  output oseq_beat_t        beat
);

  oseq_phase_e       phase_q, phase_d;
  logic [POS_W-1:0]  pos_q, pos_d;
  logic [SIZE_W-1:0] size_q, size_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [ADDR_W-1:0] nbase_q, nbase_d;

  logic issuing, last_pos, finishing, load;

  always_comb begin
    last_pos  = (pos_q == (POS_W'(size_q) + POS_W'(TAIL_LEN - 1)));
    issuing   = adv && (phase_q != PH_IDLE);
    finishing = issuing && last_pos;
    load      = adv && !fifo_empty && ((phase_q == PH_IDLE) || finishing);
  end

  // next-state logic
  always_comb begin
    phase_d = phase_q;
    pos_d   = pos_q;
    size_d  = size_q;
    base_d  = base_q;
    nbase_d = nbase_q;
    if (load) begin
      phase_d = PH_DATA;
      pos_d   = '0;
      size_d  = fifo_size;
      base_d  = nbase_q;
      nbase_d = nbase_q + ADDR_W'(fifo_size);
    end else if (finishing) begin
      phase_d = PH_IDLE;
    end else if (issuing) begin
      pos_d = pos_q + POS_W'(1);
      if (pos_d == POS_W'(size_q)) phase_d = PH_TAIL;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      pos_q   <= '0;
      size_q  <= '0;
      base_q  <= '0;
      nbase_q <= '0;
    end else begin
      phase_q <= phase_d;
      pos_q   <= pos_d;
      size_q  <= size_d;
      base_q  <= base_d;
      nbase_q <= nbase_d;
    end
  end

  always_comb begin
    fifo_pop    = load;
    rd_en       = issuing && (phase_q == PH_DATA);
    cur_pos     = pos_q;
    cur_size    = size_q;
    cur_base    = base_q;
    beat.valid  = issuing;
    beat.first  = issuing && (pos_q == '0);
    beat.last   = finishing;
    beat.tail   = issuing && (phase_q == PH_TAIL);
  end

endmodule

// File: rtl/tcc_oseq_addr.sv
module tcc_oseq_addr #(
  parameter int ADDR_W = 14,
  parameter int SIZE_W = 13,
  localparam int POS_W = SIZE_W + 1
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [POS_W-1:0]  pos,
  input  logic [SIZE_W-1:0] il_idx,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] il_addr
);

  localparam int SUM_W = (ADDR_W > POS_W) ? ADDR_W + 1 : POS_W + 1;

  logic [SUM_W-1:0] nat_sum, il_sum;

  always_comb begin
    nat_sum = SUM_W'(base) + SUM_W'(pos);
    il_sum  = SUM_W'(base) + SUM_W'(il_idx);
    rd_addr = nat_sum[ADDR_W-1:0];
    il_addr = il_sum[ADDR_W-1:0];
  end

endmodule

// File: rtl/tcc_oseq_out.sv
module tcc_oseq_out
  import tcc_oseq_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  oseq_beat_t        beat_in,
  input  logic [ADDR_W-1:0] base_in,
  output oseq_beat_t        beat_out,
  output logic              rel_valid,
  output logic [ADDR_W-1:0] rel_base
);

  oseq_beat_t        beat_q, beat_d;
  logic [ADDR_W-1:0] obase_q, obase_d;
  logic              rel_q, rel_d;
  logic [ADDR_W-1:0] rbase_q, rbase_d;

  // next-state logic
  always_comb begin
    beat_d  = beat_q;
    obase_d = obase_q;
    if (adv) begin
      beat_d  = beat_in;
      obase_d = base_in;
    end
    rel_d   = adv && beat_q.valid && beat_q.last;
    rbase_d = rel_d ? obase_q : rbase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q  <= '0;
      obase_q <= '0;
      rel_q   <= 1'b0;
      rbase_q <= '0;
    end else begin
      beat_q  <= beat_d;
      obase_q <= obase_d;
      rel_q   <= rel_d;
      rbase_q <= rbase_d;
    end
  end

  assign beat_out  = beat_q;
  assign rel_valid = rel_q;
  assign rel_base  = rbase_q;

endmodule

// File: rtl/tcc_oseq_top.sv
module tcc_oseq_top
  import tcc_oseq_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int SIZE_W   = 13,
  parameter int TAIL_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_empty_i,
  input  logic [SIZE_W-1:0] fifo_size_i,
  output logic              fifo_pop_o,
  input  logic              dn_ready_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [SIZE_W-1:0] il_idx_i,
  output logic [ADDR_W-1:0] il_addr_o,
  output logic [SIZE_W-1:0] cur_idx_o,
  output logic [SIZE_W-1:0] cur_size_o,
  output logic              out_rdy_o,
  output logic              blk_start_o,
  output logic              blk_end_o,
  output logic              tail_o,
  output logic              enc_run_o,
  output logic              rel_valid_o,
  output logic [ADDR_W-1:0] rel_base_o
);

  localparam int POS_W = SIZE_W + 1;

  logic              adv;
  logic [POS_W-1:0]  pos;
  logic [ADDR_W-1:0] base;
  oseq_beat_t        beat_iss, beat_o;

  assign adv = dn_ready_i;

  tcc_oseq_ctrl #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .TAIL_LEN(TAIL_LEN)
  ) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .fifo_empty(fifo_empty_i),
    .fifo_size (fifo_size_i),
    .fifo_pop  (fifo_pop_o),
    .rd_en     (rd_en_o),
    .cur_pos   (pos),
    .cur_size  (cur_size_o),
    .cur_base  (base),
    .beat      (beat_iss)
  );

  tcc_oseq_addr #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)
  ) addr_i (
    .base   (base),
    .pos    (pos),
    .il_idx (il_idx_i),
    .rd_addr(rd_addr_o),
    .il_addr(il_addr_o)
  );

  tcc_oseq_out #(
    .ADDR_W(ADDR_W)
  ) out_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .beat_in  (beat_iss),
    .base_in  (base),
    .beat_out (beat_o),
    .rel_valid(rel_valid_o),
    .rel_base (rel_base_o)
  );

  assign cur_idx_o   = pos[SIZE_W-1:0];
  assign out_rdy_o   = beat_o.valid;
  assign blk_start_o = beat_o.first;
  assign blk_end_o   = beat_o.last;
  assign tail_o      = beat_o.tail;
  assign enc_run_o   = beat_o.valid && adv;

endmodule

// File: rtl/tcc_oseq_chk.sv
module tcc_oseq_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dn_ready_i,
  input logic              fifo_empty_i,
  input logic              fifo_pop_o,
  input logic              rd_en_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              out_rdy_o,
  input logic              blk_start_o,
  input logic              blk_end_o,
  input logic              tail_o,
  input logic              rel_valid_o
);

  // R2
  pop_needs_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop_o |-> !fifo_empty_i);

  // R9
  frozen_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dn_ready_i |-> (!fifo_pop_o && !rd_en_o));

  // R9
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dn_ready_i |=> ($stable(out_rdy_o) && $stable(blk_start_o) &&
                     $stable(blk_end_o) && $stable(tail_o) && $stable(rd_addr_o)));

  // R5
  start_not_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start_o |-> (out_rdy_o && !blk_end_o && !tail_o));

  // R3
  end_in_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end_o |-> (out_rdy_o && tail_o));

  // R11
  rel_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid_o |-> $past(blk_end_o && dn_ready_i));

  // R11
  rel_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid_o |=> !rel_valid_o);

endmodule

bind tcc_oseq_top tcc_oseq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .dn_ready_i  (dn_ready_i),
  .fifo_empty_i(fifo_empty_i),
  .fifo_pop_o  (fifo_pop_o),
  .rd_en_o     (rd_en_o),
  .rd_addr_o   (rd_addr_o),
  .out_rdy_o   (out_rdy_o),
  .blk_start_o (blk_start_o),
  .blk_end_o   (blk_end_o),
  .tail_o      (tail_o),
  .rel_valid_o (rel_valid_o)
);

// File: tb/tcc_oseq_top_tb.sv
module tcc_oseq_top_tb_top;

  localparam int MODV = 16384;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_empty_i;
  logic [12:0] fifo_size_i;
  logic        fifo_pop_o;
  logic        dn_ready_i;
  logic        rd_en_o;
  logic [13:0] rd_addr_o;
  logic [12:0] il_idx_i;
  logic [13:0] il_addr_o;
  logic [12:0] cur_idx_o;
  logic [12:0] cur_size_o;
  logic        out_rdy_o, blk_start_o, blk_end_o, tail_o, enc_run_o;
  logic        rel_valid_o;
  logic [13:0] rel_base_o;

  always #2 clk = ~clk;

  tcc_oseq_top dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_empty_i(fifo_empty_i), .fifo_size_i(fifo_size_i),
    .fifo_pop_o(fifo_pop_o), .dn_ready_i(dn_ready_i), .rd_en_o(rd_en_o),
    .rd_addr_o(rd_addr_o), .il_idx_i(il_idx_i), .il_addr_o(il_addr_o),
    .cur_idx_o(cur_idx_o), .cur_size_o(cur_size_o), .out_rdy_o(out_rdy_o),
    .blk_start_o(blk_start_o), .blk_end_o(blk_end_o), .tail_o(tail_o),
    .enc_run_o(enc_run_o), .rel_valid_o(rel_valid_o), .rel_base_o(rel_base_o)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int q[$];
  int sizes[$];
  int bases[$];
  int st_cyc[$];
  int en_cyc[$];
  int nb = 0;
  int oblk = 0, opos = 0, rblk = 0, rpos = 0, relblk = 0;
  int ready_mode = 0;
  int pop_cyc = -1;
  bit pop_seen = 0, end_acc = 0, rdy_now = 1;
  logic p_rdy, p_st, p_en, p_tl;
  logic [13:0] p_addr;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic tick();
    int k;
    @(negedge clk);
    cyc++;
    if (pop_seen) begin
      sizes.push_back(q[0]);
      bases.push_back(nb);
      nb = (nb + q[0]) % MODV;
      q.pop_front();
    end
    // registered outputs after the edge just passed
    if (rst_n && !rdy_now) begin
      chk(out_rdy_o == p_rdy && blk_start_o == p_st && blk_end_o == p_en && tail_o == p_tl,
          "R9 beat frozen", int'(out_rdy_o), int'(p_rdy));
      chk(rd_addr_o == p_addr, "R9 address frozen", int'(rd_addr_o), int'(p_addr));
    end
    if (rel_valid_o) begin
      chk(end_acc, "R11 release without end", 1, int'(end_acc));
      if (relblk < bases.size())
        chk(int'(rel_base_o) == bases[relblk], "R11 release base", int'(rel_base_o), bases[relblk]);
      relblk++;
    end else begin
      chk(!end_acc, "R11 missing release", 0, 1);
    end
    // new inputs
    case (ready_mode)
      0: rdy_now = 1;
      1: rdy_now = ($urandom_range(0, 9) < 7);
      default: rdy_now = 0;
    endcase
    dn_ready_i   = rdy_now;
    il_idx_i     = 13'($urandom_range(0, 8191));
    fifo_empty_i = (q.size() == 0);
    fifo_size_i  = (q.size() == 0) ? 13'd0 : 13'(q[0]);
    #1;
    end_acc = 0;
    if (out_rdy_o) begin
      if (rdy_now) begin
        chk(enc_run_o, "R12 encoder run", int'(enc_run_o), 1);
        if (oblk >= sizes.size()) begin
          chk(0, "R10 beat with no block", 1, 0);
        end else begin
          k = sizes[oblk];
          chk(blk_start_o == (opos == 0), "R5 start strobe", int'(blk_start_o), int'(opos == 0));
          chk(blk_end_o == (opos == k + 3), "R5 end strobe", int'(blk_end_o), int'(opos == k + 3));
          chk(tail_o == (opos >= k), "R3 tail flag", int'(tail_o), int'(opos >= k));
          if (opos == 0) st_cyc.push_back(cyc);
          end_acc = blk_end_o;
          if (opos == k + 3) begin
            en_cyc.push_back(cyc);
            oblk++;
            opos = 0;
          end else opos++;
        end
      end else begin
        chk(!enc_run_o, "R12 encoder stalled", int'(enc_run_o), 0);
      end
    end else begin
      chk(!enc_run_o && !blk_start_o && !blk_end_o, "R12 idle strobes", int'(enc_run_o), 0);
    end
    if (!rdy_now)
      chk(!fifo_pop_o && !rd_en_o, "R9 no pop or read while frozen", int'(fifo_pop_o), 0);
    if (rd_en_o) begin
      if (rblk >= sizes.size()) chk(0, "R6 read with no block", 1, 0);
      else begin
        chk(int'(rd_addr_o) == (bases[rblk] + rpos) % MODV, "R6 R7 read address",
            int'(rd_addr_o), (bases[rblk] + rpos) % MODV);
        chk(int'(cur_idx_o) == rpos, "R6 index", int'(cur_idx_o), rpos);
        chk(int'(il_addr_o) == (bases[rblk] + int'(il_idx_i)) % MODV, "R8 interleaved address",
            int'(il_addr_o), (bases[rblk] + int'(il_idx_i)) % MODV);
        rpos++;
        if (rpos == sizes[rblk]) begin rblk++; rpos = 0; end
      end
    end
    if (fifo_pop_o) begin
      chk(q.size() != 0, "R2 pop on empty", 1, 0);
      pop_cyc = cyc;
    end
    pop_seen = fifo_pop_o;
    p_rdy = out_rdy_o; p_st = blk_start_o; p_en = blk_end_o; p_tl = tail_o; p_addr = rd_addr_o;
  endtask

  task automatic drain();
    int guard = 0;
    while (!(q.size() == 0 && !pop_seen && oblk == sizes.size() && relblk == sizes.size())
           && guard < 40000) begin
      tick();
      guard++;
    end
    chk(guard < 40000, "R3 drain completes", guard, 0);
  endtask

  initial begin
    int first_blk, pc, sc;
    void'($urandom(4242));
    dn_ready_i = 1; il_idx_i = '0; fifo_empty_i = 1; fifo_size_i = '0;
    p_rdy = 0; p_st = 0; p_en = 0; p_tl = 0; p_addr = '0;
    // reset state
    repeat (3) tick();
    chk(!out_rdy_o && !blk_start_o && !blk_end_o && !tail_o && !enc_run_o && !rd_en_o && !rel_valid_o,
        "R1 reset outputs", int'(out_rdy_o), 0);
    @(negedge clk); rst_n = 1;
    repeat (2) tick();
    chk(!out_rdy_o, "R1 idle after reset", int'(out_rdy_o), 0);

    // latency from pop to first start, first base zero
    q.push_back(40);
    pc = -1; sc = -1;
    for (int i = 0; i < 10; i++) begin
      tick();
      if (fifo_pop_o && pc < 0) pc = cyc;
      if (blk_start_o && sc < 0) sc = cyc;
    end
    chk(sc - pc == 2, "R2 start two edges after pop", sc - pc, 2);
    chk(bases[0] == 0, "R7 first base", bases[0], 0);
    drain();
    repeat (3) tick();
    chk(!out_rdy_o, "R10 ready low when fifo empty", int'(out_rdy_o), 0);

    // back to back, including length 1
    first_blk = sizes.size();
    q.push_back(3); q.push_back(1); q.push_back(40); q.push_back(7); q.push_back(1);
    drain();
    for (int b = first_blk; b < sizes.size(); b++) begin
      chk(en_cyc[b] - st_cyc[b] == sizes[b] + 3, "R3 beats per block", en_cyc[b] - st_cyc[b], sizes[b] + 3);
      if (b > first_blk)
        chk(st_cyc[b] == en_cyc[b-1] + 1, "R4 no gap", st_cyc[b], en_cyc[b-1] + 1);
    end

    // stall over a queued boundary
    q.push_back(2); q.push_back(2);
    repeat (4) tick();
    ready_mode = 2; repeat (5) tick();
    ready_mode = 0; tick();
    ready_mode = 2; repeat (3) tick();
    ready_mode = 0;
    drain();

    // random lengths and stalls, with large blocks to wrap the address space
    ready_mode = 1;
    for (int g = 0; g < 5; g++) begin
      for (int j = 0; j < 5; j++) q.push_back($urandom_range(1, 600));
      if (g == 2) begin q.push_back(6144); q.push_back(6144); q.push_back(6144); end
      drain();
    end
    ready_mode = 0;
    repeat (4) tick();
    chk(!out_rdy_o && oblk == sizes.size(), "R10 ready low after final block", int'(out_rdy_o), 0);
    chk(nb < MODV && sizes.size() > 20, "R7 wrap exercised", nb, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule